// File: doc/BRIEF.md
# Timer-Compare Conversion Trigger

This block lets a free-running timer pace analog-to-digital conversions without software in the loop. Two 16-bit timers count on their own increment strobes. A compare unit watches the timer picked by configuration. When the compare function is set to its trigger mode and that timer reaches the programmed compare value, the unit emits a one-cycle event. The event always restarts the watched timer from zero, so the sampling period repeats by itself. If the converter is enabled and idle, the event also starts a conversion.

A started conversion first waits out a programmable acquisition time. It then sends a one-cycle request to the external converter and waits for the converter's done pulse, which comes with a 10-bit sample. The sample is latched into a high/low byte pair, the busy flag drops and a one-cycle completion flag is raised. Software only has to collect the byte pair before the next event. Clearing the converter enable during a conversion cancels it.

Top module: `cmp_adc_trigger`

## Requirements
- R1: `special_evt` is high for a cycle only when `cfg_mode` equals binary 1011 and the timer selected by `cfg_timer_sel` (0 picks timer 0, 1 picks timer 1) holds `cfg_compare` in that cycle. Any other mode value produces no event and does not disturb the timers.
- R2: An event seen while `cfg_adc_en` is 1 and `busy` is 0 makes `busy` read 1 in the following cycle.
- R3: In the cycle after an event, the selected timer reads zero. The unselected timer keeps its normal count.
- R4: With `cfg_adc_en` at 0, an event leaves `busy` at 0 but still clears the selected timer.
- R5: After a start, `conv_req` pulses high for exactly one cycle, 2+N cycles after the event cycle. N is the acquisition time chosen by `cfg_acq_sel` codes 0..7 from the set 0, 2, 4, 6, 8, 12, 16, 20, in clock cycles.
- R6: A `conv_done` pulse during a conversion clears `busy` in the next cycle and raises `done_irq` for exactly that one cycle.
- R7: The sample on `conv_data` with `conv_done` appears in the same cycle as `done_irq`: `res_hi` = {6'b0, data[9:8]}, `res_lo` = data[7:0]. The result changes at no other time.
- R8: An event that arrives while `busy` is 1 starts no new conversion and issues no extra `conv_req`, but still clears the selected timer.
- R9: Dropping `cfg_adc_en` while `busy` is 1 clears `busy` in the next cycle, raises no `done_irq` and keeps the previous result.
- R10: After reset, both timers, `busy`, `conv_req`, `done_irq`, `res_hi` and `res_lo` are zero.
- R11: A `conv_done` pulse while no conversion is pending is ignored: no `done_irq`, and the result does not change.
- R12: Each timer advances by one only in cycles where its increment input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 4 | Compare function select; 1011 enables the conversion trigger |
| cfg_compare | input | 16 | Compare value |
| cfg_timer_sel | input | 1 | Timer watched and cleared by the compare unit |
| cfg_adc_en | input | 1 | Converter enable; low cancels a conversion |
| cfg_acq_sel | input | 3 | Acquisition time code |
| tmr0_inc | input | 1 | Count strobe of timer 0 |
| tmr1_inc | input | 1 | Count strobe of timer 1 |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter sample, valid with conv_done |
| tmr0_val | output | 16 | Timer 0 count |
| tmr1_val | output | 16 | Timer 1 count |
| special_evt | output | 1 | One-cycle compare event |
| busy | output | 1 | Conversion in progress |
| conv_req | output | 1 | One-cycle request to the converter |
| done_irq | output | 1 | One-cycle completion flag |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |

## Verification
The compare event and the converter's done pulse can land in the same cycle. The sequencer then has to finish the running conversion, ignore the event as a start, and the timer must still restart. The bench provokes this by holding the automatic responder off and driving `conv_done` by hand in exactly the cycle where the next compare event is high. It then expects the next cycle to show `done_irq`, the hand-driven sample, `busy` low and the timer at zero. Over the following cycles it expects no new request.

// File: rtl/cmp_adc_pkg.sv
package cmp_adc_pkg;

  localparam logic [3:0] TRIG_MODE = 4'b1011;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACQ  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_t;

  // acquisition time in units for each 3-bit code
  function automatic logic [4:0] acq_units(input logic [2:0] code);
    logic [4:0] u;
    case (code)
      3'd0: u = 5'd0;
      3'd1: u = 5'd2;
      3'd2: u = 5'd4;
      3'd3: u = 5'd6;
      3'd4: u = 5'd8;
      3'd5: u = 5'd12;
      3'd6: u = 5'd16;
      default: u = 5'd20;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/cat_timer.sv
module cat_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [TMR_W-1:0] value
);

  logic [TMR_W-1:0] cnt_q;

  // clear dominates counting
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + TMR_W'(1);
    end
  end

  assign value = cnt_q;

endmodule

// File: rtl/cat_compare.sv
module cat_compare
  import cmp_adc_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [TMR_W-1:0]  cmp_val,
  input  logic [TMR_W-1:0]  cnt,
  output logic              hit
);

  logic mode_ok;
  logic equal;

  always_comb begin
    mode_ok = (mode == MODE_W'(TRIG_MODE));
    equal   = (cnt == cmp_val);
    hit     = mode_ok && equal;
  end

endmodule

// File: rtl/cat_sequencer.sv
module cat_sequencer
  import cmp_adc_pkg::*;
#(
  parameter int UNIT_CYCLES = 1,
  parameter int ACQ_SEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt,
  input  logic                 adc_en,
  input  logic [ACQ_SEL_W-1:0] acq_sel,
  input  logic                 conv_done,
  output logic                 busy,
  output logic                 conv_req,
  output logic                 done_irq,
  output logic                 capture
);

  localparam int ACQ_MAX = 20 * UNIT_CYCLES;
  localparam int CW      = (ACQ_MAX < 2) ? 1 : $clog2(ACQ_MAX + 1);

  seq_state_t    state_q;
  logic [CW-1:0] wait_q;
  logic [CW-1:0] acq_load;
  logic          req_q;
  logic          irq_q;
  logic          start;

  always_comb begin
    acq_load = CW'(int'(acq_units(3'(acq_sel))) * UNIT_CYCLES);
    start    = evt && adc_en && (state_q == SEQ_IDLE);
    capture  = (state_q == SEQ_CONV) && adc_en && conv_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      wait_q  <= '0;
      req_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_ACQ;
            wait_q  <= acq_load;
          end
        end
        SEQ_ACQ: begin
          if (!adc_en) begin
            state_q <= SEQ_IDLE;
          end else if (wait_q == '0) begin
            req_q   <= 1'b1;
            state_q <= SEQ_CONV;
          end else begin
            wait_q <= wait_q - CW'(1);
          end
        end
        SEQ_CONV: begin
          if (!adc_en) begin
            state_q <= SEQ_IDLE;
          end else if (conv_done) begin
            state_q <= SEQ_IDLE;
            irq_q   <= 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign conv_req = req_q;
  assign done_irq = irq_q;

endmodule

// File: rtl/cat_result.sv
module cat_result #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [RES_W-1:0] data,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);

  localparam int PAD_W = 16 - RES_W;

  logic [15:0] word_q;
  logic [15:0] word_d;

  always_comb begin
    word_d = {{PAD_W{1'b0}}, data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (capture) begin
      word_q <= word_d;
    end
  end

  assign res_hi = word_q[15:8];
  assign res_lo = word_q[7:0];

endmodule

// File: rtl/cmp_adc_trigger.sv
module cmp_adc_trigger
  import cmp_adc_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int MODE_W      = 4,
  parameter int ACQ_SEL_W   = 3,
  parameter int RES_W       = 10,
  parameter int UNIT_CYCLES = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic [TMR_W-1:0]     cfg_compare,
  input  logic                 cfg_timer_sel,
  input  logic                 cfg_adc_en,
  input  logic [ACQ_SEL_W-1:0] cfg_acq_sel,
  input  logic                 tmr0_inc,
  input  logic                 tmr1_inc,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  output logic [TMR_W-1:0]     tmr0_val,
  output logic [TMR_W-1:0]     tmr1_val,
  output logic                 special_evt,
  output logic                 busy,
  output logic                 conv_req,
  output logic                 done_irq,
  output logic [7:0]           res_hi,
  output logic [7:0]           res_lo
);

  localparam int NUM_TMR = 2;

  logic [TMR_W-1:0] tval [NUM_TMR];
  logic [NUM_TMR-1:0] inc_vec;
  logic [NUM_TMR-1:0] clr_vec;
  logic [TMR_W-1:0] watched;
  logic             evt;
  logic             capture;

  assign inc_vec = {tmr1_inc, tmr0_inc};

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign clr_vec[g] = evt && (cfg_timer_sel == 1'(g));
    cat_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc_vec[g]),
      .clr   (clr_vec[g]),
      .value (tval[g])
    );
  end

  assign watched = cfg_timer_sel ? tval[1] : tval[0];

  cat_compare #(.TMR_W(TMR_W), .MODE_W(MODE_W)) u_cmp (
    .mode    (cfg_mode),
    .cmp_val (cfg_compare),
    .cnt     (watched),
    .hit     (evt)
  );

  cat_sequencer #(.UNIT_CYCLES(UNIT_CYCLES), .ACQ_SEL_W(ACQ_SEL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .adc_en    (cfg_adc_en),
    .acq_sel   (cfg_acq_sel),
    .conv_done (conv_done),
    .busy      (busy),
    .conv_req  (conv_req),
    .done_irq  (done_irq),
    .capture   (capture)
  );

  cat_result #(.RES_W(RES_W)) u_res (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .data    (conv_data),
    .res_hi  (res_hi),
    .res_lo  (res_lo)
  );

  assign tmr0_val    = tval[0];
  assign tmr1_val    = tval[1];
  assign special_evt = evt;

endmodule

// File: rtl/cat_checker.sv
module cat_checker #(
  parameter int TMR_W  = 16,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              cfg_timer_sel,
  input logic              cfg_adc_en,
  input logic [TMR_W-1:0]  tmr0_val,
  input logic [TMR_W-1:0]  tmr1_val,
  input logic              special_evt,
  input logic              busy,
  input logic              conv_req,
  input logic              done_irq,
  input logic [7:0]        res_hi,
  input logic [7:0]        res_lo
);

  p_evt_mode_r1: assert property (@(posedge clk) disable iff (rst)
    special_evt |-> (cfg_mode == MODE_W'(4'b1011)));

  p_evt_start_r2: assert property (@(posedge clk) disable iff (rst)
    (special_evt && cfg_adc_en && !busy) |=> busy);

  p_evt_clear0_r3: assert property (@(posedge clk) disable iff (rst)
    (special_evt && !cfg_timer_sel) |=> (tmr0_val == '0));

  p_evt_clear1_r3: assert property (@(posedge clk) disable iff (rst)
    (special_evt && cfg_timer_sel) |=> (tmr1_val == '0));

  p_off_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfg_adc_en) |=> !busy);

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  p_req_busy_r5: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> busy);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_irq |-> $stable({res_hi, res_lo}));

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_adc_en) |=> (!busy && !done_irq));

  p_stray_done_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !done_irq);

endmodule

bind cmp_adc_trigger cat_checker #(.TMR_W(TMR_W), .MODE_W(MODE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_mode      (cfg_mode),
  .cfg_timer_sel (cfg_timer_sel),
  .cfg_adc_en    (cfg_adc_en),
  .tmr0_val      (tmr0_val),
  .tmr1_val      (tmr1_val),
  .special_evt   (special_evt),
  .busy          (busy),
  .conv_req      (conv_req),
  .done_irq      (done_irq),
  .res_hi        (res_hi),
  .res_lo        (res_lo)
);

// File: tb/sim_cmp_adc_trigger.sv
`timescale 1ns/1ps
module sim_cmp_adc_trigger;

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] cmp;
    logic        sel;
    logic        en;
    logic [2:0]  acq;
    logic [9:0]  data;
    logic        exp_evt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    vec_t'({4'b1011, 16'd10, 1'b0, 1'b1, 3'd0, 10'h3A5, 1'b1}),
    vec_t'({4'b1011, 16'd25, 1'b1, 1'b1, 3'd3, 10'h2C1, 1'b1}),
    vec_t'({4'b1011, 16'd12, 1'b0, 1'b0, 3'd1, 10'h111, 1'b1}),
    vec_t'({4'b1010, 16'd8,  1'b0, 1'b1, 3'd0, 10'h222, 1'b0}),
    vec_t'({4'b1011, 16'd5,  1'b1, 1'b1, 3'd7, 10'h155, 1'b1}),
    vec_t'({4'b1011, 16'd40, 1'b0, 1'b1, 3'd5, 10'h0FF, 1'b1})
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_mode = '0;
  logic [15:0] cfg_compare = '0;
  logic        cfg_timer_sel = 1'b0;
  logic        cfg_adc_en = 1'b0;
  logic [2:0]  cfg_acq_sel = '0;
  logic        tmr0_inc = 1'b1;
  logic        tmr1_inc = 1'b1;
  logic        conv_done;
  logic [9:0]  conv_data;
  logic [15:0] tmr0_val, tmr1_val;
  logic        special_evt, busy, conv_req, done_irq;
  logic [7:0]  res_hi, res_lo;

  logic        rsp_en = 1'b0;
  logic [9:0]  rsp_data = '0;
  logic        rsp_done = 1'b0;
  int          rsp_cnt = 0;
  logic        man_done = 1'b0;
  logic [9:0]  man_data = '0;
  int          req_seen = 0;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  assign conv_done = rsp_done | man_done;
  assign conv_data = man_done ? man_data : rsp_data;

  cmp_adc_trigger u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_compare(cfg_compare),
    .cfg_timer_sel(cfg_timer_sel), .cfg_adc_en(cfg_adc_en), .cfg_acq_sel(cfg_acq_sel),
    .tmr0_inc(tmr0_inc), .tmr1_inc(tmr1_inc), .conv_done(conv_done), .conv_data(conv_data),
    .tmr0_val(tmr0_val), .tmr1_val(tmr1_val), .special_evt(special_evt), .busy(busy),
    .conv_req(conv_req), .done_irq(done_irq), .res_hi(res_hi), .res_lo(res_lo)
  );

  // fixed-latency converter model, driven away from the active edge
  always @(negedge clk) begin
    if (conv_req) req_seen <= req_seen + 1;
    rsp_done <= 1'b0;
    if (rst || !rsp_en) begin
      rsp_cnt <= 0;
    end else if (rsp_cnt != 0) begin
      rsp_cnt <= rsp_cnt - 1;
      if (rsp_cnt == 1) rsp_done <= 1'b1;
    end else if (conv_req) begin
      rsp_cnt <= 3;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sel_tmr();
    return cfg_timer_sel ? tmr1_val : tmr0_val;
  endfunction

  function automatic logic [15:0] oth_tmr();
    return cfg_timer_sel ? tmr0_val : tmr1_val;
  endfunction

  function automatic int exp_acq(input logic [2:0] c);
    int t [8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return t[c];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [15:0] snap0, snap1;
    logic [15:0] other;
    logic [7:0]  keep_hi, keep_lo;
    int          req_before;
    bit          found;

    // R10: reset state
    do_reset();
    chk("R10 tmr0 after reset", tmr0_val, 0);
    chk("R10 tmr1 after reset", tmr1_val, 0);
    chk("R10 busy after reset", busy, 0);
    chk("R10 conv_req after reset", conv_req, 0);
    chk("R10 done_irq after reset", done_irq, 0);
    chk("R10 result after reset", {res_hi, res_lo}, 0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VEC[v];
      cfg_mode = t.mode; cfg_compare = t.cmp; cfg_timer_sel = t.sel;
      cfg_adc_en = t.en; cfg_acq_sel = t.acq; rsp_data = t.data; rsp_en = 1'b1;
      do_reset();
      found = 0;
      for (int k = 1; k <= int'(t.cmp) + 5; k++) begin
        @(negedge clk);
        if (special_evt) begin found = 1; break; end
      end
      chk("R1 event presence", found, t.exp_evt);
      if (t.exp_evt) begin
        chk("R1 event at compare value", sel_tmr(), t.cmp);
        other = oth_tmr();
        @(negedge clk);
        chk("R3 selected timer cleared", sel_tmr(), 0);
        chk("R3 other timer counts on", oth_tmr(), other + 16'd1);
        if (t.en) begin
          int d;
          chk("R2 busy after event", busy, 1);
          d = 1;
          while (!conv_req && d < 40) begin @(negedge clk); d++; end
          chk("R5 request delay", d, exp_acq(t.acq) + 2);
          @(negedge clk);
          chk("R5 request is one cycle", conv_req, 0);
          found = 0;
          for (int k = 0; k < 20; k++) begin
            if (done_irq) begin found = 1; break; end
            @(negedge clk);
          end
          chk("R6 done_irq raised", found, 1);
          chk("R6 busy cleared with done_irq", busy, 0);
          chk("R7 result high byte", res_hi, {6'b0, t.data[9:8]});
          chk("R7 result low byte", res_lo, t.data[7:0]);
          @(negedge clk);
          chk("R6 done_irq one cycle", done_irq, 0);
        end else begin
          chk("R4 busy stays low when disabled", busy, 0);
        end
      end else begin
        chk("R1 timer ran past compare", sel_tmr(), t.cmp + 16'd5);
      end
    end

    // R12 increment strobes, R11 stray done
    cfg_mode = 4'b0000; cfg_adc_en = 1'b1; rsp_en = 1'b0; cfg_timer_sel = 1'b0;
    do_reset();
    tmr0_inc = 1'b0;
    @(negedge clk);
    snap0 = tmr0_val; snap1 = tmr1_val;
    repeat (5) @(negedge clk);
    chk("R12 timer0 held", tmr0_val, snap0);
    chk("R12 timer1 advanced", tmr1_val, snap1 + 16'd5);
    tmr0_inc = 1'b1; tmr1_inc = 1'b0;
    @(negedge clk);
    snap0 = tmr0_val; snap1 = tmr1_val;
    repeat (3) @(negedge clk);
    chk("R12 timer0 advanced", tmr0_val, snap0 + 16'd3);
    chk("R12 timer1 held", tmr1_val, snap1);
    tmr1_inc = 1'b1;
    man_data = 10'h3FF; man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    chk("R11 no done_irq from stray done", done_irq, 0);
    chk("R11 result untouched", {res_hi, res_lo}, 0);
    @(negedge clk);
    chk("R11 still no done_irq", done_irq, 0);

    // R8 trigger while busy, then R9 abort
    cfg_mode = 4'b1011; cfg_compare = 16'd6; cfg_timer_sel = 1'b0;
    cfg_acq_sel = 3'd0; cfg_adc_en = 1'b1; rsp_en = 1'b1; rsp_data = 10'h0C3;
    do_reset();
    while (!done_irq) @(negedge clk);
    keep_hi = res_hi; keep_lo = res_lo;
    rsp_en = 1'b0;
    while (!special_evt) @(negedge clk);
    req_before = req_seen;
    @(negedge clk);
    chk("R2 busy for second run", busy, 1);
    while (!special_evt) @(negedge clk);
    chk("R8 busy at overlapping event", busy, 1);
    @(negedge clk);
    chk("R8 timer cleared by overlapping event", tmr0_val, 0);
    repeat (4) @(negedge clk);
    chk("R8 single request", req_seen - req_before, 1);
    cfg_adc_en = 1'b0;
    @(negedge clk);
    chk("R9 busy cleared by abort", busy, 0);
    chk("R9 no done_irq on abort", done_irq, 0);
    chk("R9 result kept", {res_hi, res_lo}, {keep_hi, keep_lo});
    while (!special_evt) @(negedge clk);
    @(negedge clk);
    chk("R4 timer cleared while disabled", tmr0_val, 0);
    chk("R4 busy low while disabled", busy, 0);

    // event and done in the same cycle
    cfg_compare = 16'd15; cfg_adc_en = 1'b1; rsp_en = 1'b0;
    do_reset();
    while (!special_evt) @(negedge clk);
    while (!conv_req) @(negedge clk);
    @(negedge clk);
    while (!special_evt) @(negedge clk);
    chk("R8 busy when done meets event", busy, 1);
    man_data = 10'h2B7; man_done = 1'b1;
    req_before = req_seen;
    @(negedge clk);
    man_done = 1'b0;
    chk("R6 done_irq on coincident done", done_irq, 1);
    chk("R6 busy cleared on coincident done", busy, 0);
    chk("R7 coincident result", {res_hi, res_lo}, 16'h02B7);
    chk("R3 timer cleared on coincident event", tmr0_val, 0);
    repeat (3) @(negedge clk);
    chk("R8 coincident event starts nothing", busy, 0);
    chk("R8 no request after coincident event", req_seen - req_before, 0);

    report();
  end

endmodule